// File: doc/BRIEF.md
# Wide Group Register Renamer

This block renames a whole group of instructions in one clock cycle. Each slot in the group has two architectural source registers and can have one architectural destination. The sources of a slot are mapped to physical tags. If an older slot in the same group writes the same architectural register, that older slot's newly allocated tag is used. Otherwise the source reads the mapping held in the table. Each slot that writes a destination takes one fresh physical tag from the free-register supply. That slot also reports the physical tag its destination mapped to before, so the register can be released when the instruction retires. When several slots write one architectural register, the table keeps the mapping of the youngest of those slots.

The group arrives on a valid/ready input and leaves on a valid/ready output that passes straight through. Rename happens in the cycle the group is accepted. Back-pressure has two sources. The first is the consumer lowering `out_ready`. The second is the free-register supply holding fewer tags than the group needs. In either case the whole group waits, and neither the table nor the supply changes. `in_ready` never depends on `in_valid`. The supply presents its next tags in order on `free_tags`, together with a count. The block reports how many of them it used on `free_take`.

Top module: `group_renamer`

## Requirements
- R1: After reset, every architectural register r maps to physical tag r.
- R2: A source that no older writing slot in the group names returns the table's current mapping for that register.
- R3: A source that one or more older writing slots name returns the tag allocated to the youngest of them. A slot's own destination never feeds its own sources.
- R4: Writing slots (slot valid and has-destination both 1) are counted in slot order from slot 0. The k-th of them receives lane k of `free_tags` (bits k*PW upward). On an accepted group, `free_take` equals the number of writing slots; otherwise it is 0.
- R5: A slot that is invalid or has no destination reports 0 on its new and old destination tags. It takes no tag and leaves the table untouched.
- R6: A writing slot's old tag is the mapping its destination had just before that slot. This is the youngest older in-group writer's new tag if one exists, and the table entry otherwise.
- R7: When several accepted slots write one architectural register, the table afterwards holds the youngest slot's tag.
- R8: If `free_cnt` is less than the number of writing slots, then `in_ready` and `out_valid` are 0, `free_take` is 0, and no mapping changes.
- R9: `out_valid` = `in_valid` AND enough tags. `in_ready` = `out_ready` AND enough tags. The table changes only when `in_valid` and `in_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group present |
| in_ready | output | 1 | Group accepted this cycle when in_valid is also 1 |
| slot_vld | input | G | Per-slot valid |
| slot_has_dst | input | G | Per-slot destination present |
| src_a | input | G*AW | First architectural source per slot |
| src_b | input | G*AW | Second architectural source per slot |
| dst | input | G*AW | Architectural destination per slot |
| free_cnt | input | CW | Number of usable tags on free_tags |
| free_tags | input | G*PW | Next free physical tags, lane 0 first |
| free_take | output | CW | Tags used this cycle |
| out_valid | output | 1 | Renamed group present |
| out_ready | input | 1 | Consumer accepts the renamed group |
| psrc_a | output | G*PW | Physical first source per slot |
| psrc_b | output | G*PW | Physical second source per slot |
| pdst | output | G*PW | New physical destination per slot |
| pold | output | G*PW | Previous physical destination per slot |

## Verification
The assertions check five things on every cycle:
- the block never uses more tags than the supply offers;
- a stalled group takes no tags;
- the table holds still on any cycle with no write;
- slot 0's sources come straight from the table;
- non-writing slots report zero tags.

Some behaviours need a reference model in the bench and can only be shown by its scenarios: in-group forwarding through chains of older writers, correct old tags after same-register overwrites inside one group, youngest-writer-wins in the table, and stalled groups leaving no trace. The bench drives thousands of groups over a narrow register space so that collisions are frequent. It compares every slot against a sequential model.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_GROUP = 8;
  localparam int unsigned RN_ARCH  = 32;
  localparam int unsigned RN_PHYS  = 128;

  function automatic int unsigned rn_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int unsigned G  = 8,
  parameter int unsigned PW = 7,
  parameter int unsigned CW = 4
) (
  input  logic [G-1:0]  wr,
  input  logic [PW-1:0] free_tags [G],
  output logic [PW-1:0] new_tag   [G],
  output logic [CW-1:0] need
);
  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < G; i++) begin
      new_tag[i] = '0;
      if (wr[i]) begin
        new_tag[i] = free_tags[cnt];
        cnt = cnt + 1;
      end
    end
    need = CW'(cnt);
  end
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
  parameter int unsigned G  = 8,
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 7
) (
  input  logic [G-1:0]  wr,
  input  logic [AW-1:0] src_a   [G],
  input  logic [AW-1:0] src_b   [G],
  input  logic [AW-1:0] dst     [G],
  input  logic [PW-1:0] map_a   [G],
  input  logic [PW-1:0] map_b   [G],
  input  logic [PW-1:0] map_d   [G],
  input  logic [PW-1:0] new_tag [G],
  output logic [PW-1:0] psrc_a  [G],
  output logic [PW-1:0] psrc_b  [G],
  output logic [PW-1:0] pold    [G]
);
  // older slots scanned oldest first, so the youngest match lands last
  always_comb begin
    for (int i = 0; i < G; i++) begin
      psrc_a[i] = map_a[i];
      psrc_b[i] = map_b[i];
      pold[i]   = map_d[i];
      for (int j = 0; j < i; j++) begin
        if (wr[j] && dst[j] == src_a[i]) psrc_a[i] = new_tag[j];
        if (wr[j] && dst[j] == src_b[i]) psrc_b[i] = new_tag[j];
        if (wr[j] && dst[j] == dst[i])   pold[i]   = new_tag[j];
      end
      if (!wr[i]) pold[i] = '0;
    end
  end
endmodule

// File: rtl/rn_map.sv
module rn_map #(
  parameter int unsigned G    = 8,
  parameter int unsigned ARCH = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned PW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra   [G],
  input  logic [AW-1:0] rb   [G],
  input  logic [AW-1:0] rd   [G],
  output logic [PW-1:0] da   [G],
  output logic [PW-1:0] db   [G],
  output logic [PW-1:0] dd   [G],
  input  logic [G-1:0]  wen,
  input  logic [AW-1:0] wdst [G],
  input  logic [PW-1:0] wtag [G]
);
  logic [PW-1:0] table_q [ARCH];

  always_comb begin
    for (int i = 0; i < G; i++) begin
      da[i] = table_q[ra[i]];
      db[i] = table_q[rb[i]];
      dd[i] = table_q[rd[i]];
    end
  end

  // later slots are written after earlier ones: the youngest writer wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH; r++) table_q[r] <= PW'(r);
    end else begin
      for (int i = 0; i < G; i++)
        if (wen[i]) table_q[wdst[i]] <= wtag[i];
    end
  end

  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen == '0) |=> $stable(table_q[0]) && $stable(table_q[ARCH-1]));
endmodule

// File: rtl/group_renamer.sv
module group_renamer
  import rn_pkg::*;
#(
  parameter int unsigned G    = RN_GROUP,
  parameter int unsigned ARCH = RN_ARCH,
  parameter int unsigned PHYS = RN_PHYS,
  localparam int unsigned AW  = rn_bits(ARCH),
  localparam int unsigned PW  = rn_bits(PHYS),
  localparam int unsigned CW  = rn_bits(G + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [G-1:0]  slot_vld,
  input  logic [G-1:0]  slot_has_dst,
  input  logic [G*AW-1:0] src_a,
  input  logic [G*AW-1:0] src_b,
  input  logic [G*AW-1:0] dst,
  input  logic [CW-1:0] free_cnt,
  input  logic [G*PW-1:0] free_tags,
  output logic [CW-1:0] free_take,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [G*PW-1:0] psrc_a,
  output logic [G*PW-1:0] psrc_b,
  output logic [G*PW-1:0] pdst,
  output logic [G*PW-1:0] pold
);
  logic [AW-1:0] sa [G], sb [G], sd [G];
  logic [PW-1:0] ft [G], nt [G], ma [G], mb [G], md [G];
  logic [PW-1:0] pa [G], pb [G], po [G];
  logic [G-1:0]  wr, wen;
  logic [CW-1:0] need;
  logic          enough, fire;

  for (genvar i = 0; i < G; i++) begin : g_lane
    assign sa[i] = src_a[i*AW +: AW];
    assign sb[i] = src_b[i*AW +: AW];
    assign sd[i] = dst[i*AW +: AW];
    assign ft[i] = free_tags[i*PW +: PW];
    assign psrc_a[i*PW +: PW] = pa[i];
    assign psrc_b[i*PW +: PW] = pb[i];
    assign pdst[i*PW +: PW]   = nt[i];
    assign pold[i*PW +: PW]   = po[i];

    // R5
    idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot_vld[i] && slot_has_dst[i]) |-> (pdst[i*PW +: PW] == '0 && pold[i*PW +: PW] == '0));
  end

  assign wr        = slot_vld & slot_has_dst;
  assign enough    = (free_cnt >= need);
  assign out_valid = in_valid & enough;
  assign in_ready  = out_ready & enough;
  assign fire      = in_valid & in_ready;
  assign wen       = fire ? wr : '0;
  assign free_take = fire ? need : '0;

  rn_alloc #(.G(G), .PW(PW), .CW(CW)) u_alloc (
    .wr(wr), .free_tags(ft), .new_tag(nt), .need(need));

  rn_map #(.G(G), .ARCH(ARCH), .AW(AW), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n), .ra(sa), .rb(sb), .rd(sd),
    .da(ma), .db(mb), .dd(md), .wen(wen), .wdst(sd), .wtag(nt));

  rn_bypass #(.G(G), .AW(AW), .PW(PW)) u_byp (
    .wr(wr), .src_a(sa), .src_b(sb), .dst(sd),
    .map_a(ma), .map_b(mb), .map_d(md), .new_tag(nt),
    .psrc_a(pa), .psrc_b(pb), .pold(po));

  // R8
  no_overdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_take <= free_cnt);
  // R8
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (free_take == '0 && wen == '0));
  // R2
  slot0_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa[0] == ma[0] && pb[0] == mb[0]));
endmodule

// File: tb/sim_group_renamer.sv
module sim_group_renamer;
  localparam int G = 4, ARCH = 8, PHYS = 16, AW = 3, PW = 4, CW = 3;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic in_valid, in_ready, out_valid, out_ready;
  logic [G-1:0] slot_vld, slot_has_dst;
  logic [G*AW-1:0] src_a, src_b, dst;
  logic [CW-1:0] free_cnt, free_take;
  logic [G*PW-1:0] free_tags, psrc_a, psrc_b, pdst, pold;

  group_renamer #(.G(G), .ARCH(ARCH), .PHYS(PHYS)) u0 (.*);

  int checks = 0, fails = 0;
  int model [ARCH];
  int sa [G], sb [G], sd [G], tg [G];
  bit vl [G], hd [G];
  int fc;
  bit iv, ordy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic apply_and_check();
    int tmp [ARCH];
    int k, need, e_psa, e_psb, e_pd, e_po;
    bit enough, fire, fwd;
    @(negedge clk);
    in_valid = iv; out_ready = ordy; free_cnt = CW'(fc);
    for (int i = 0; i < G; i++) begin
      slot_vld[i] = vl[i]; slot_has_dst[i] = hd[i];
      src_a[i*AW +: AW] = AW'(sa[i]); src_b[i*AW +: AW] = AW'(sb[i]);
      dst[i*AW +: AW] = AW'(sd[i]); free_tags[i*PW +: PW] = PW'(tg[i]);
    end
    #1;
    tmp = model; k = 0;
    for (int i = 0; i < G; i++) begin
      e_psa = tmp[sa[i]]; e_psb = tmp[sb[i]]; e_pd = 0; e_po = 0;
      if (vl[i] && hd[i]) begin
        e_pd = tg[k]; k++; e_po = tmp[sd[i]]; tmp[sd[i]] = e_pd;
      end
      if (vl[i]) begin
        fwd = 0;
        for (int j = 0; j < i; j++) if (vl[j] && hd[j] && sd[j] == sa[i]) fwd = 1;
        if (fwd) chk(psrc_a[i*PW +: PW] == PW'(e_psa), "R3 src_a", int'(psrc_a[i*PW +: PW]), e_psa);
        else     chk(psrc_a[i*PW +: PW] == PW'(e_psa), "R2 src_a", int'(psrc_a[i*PW +: PW]), e_psa);
        chk(psrc_b[i*PW +: PW] == PW'(e_psb), "R2/R3 src_b", int'(psrc_b[i*PW +: PW]), e_psb);
      end
      if (vl[i] && hd[i]) chk(pdst[i*PW +: PW] == PW'(e_pd), "R4 pdst", int'(pdst[i*PW +: PW]), e_pd);
      else                chk(pdst[i*PW +: PW] == '0 && pold[i*PW +: PW] == '0, "R5 idle slot", int'(pdst[i*PW +: PW]), 0);
      if (vl[i] && hd[i]) chk(pold[i*PW +: PW] == PW'(e_po), "R6 pold", int'(pold[i*PW +: PW]), e_po);
    end
    need = k; enough = (fc >= need);
    fire = iv && ordy && enough;
    chk(out_valid == (iv && enough), "R9 out_valid", int'(out_valid), int'(iv && enough));
    chk(in_ready == (ordy && enough), "R8 in_ready", int'(in_ready), int'(ordy && enough));
    chk(int'(free_take) == (fire ? need : 0), "R4 free_take", int'(free_take), fire ? need : 0);
    @(posedge clk);
    if (fire) model = tmp;
  endtask

  task automatic read_all(input string req);
    // group with no destinations that reads every register
    for (int i = 0; i < G; i++) begin
      vl[i] = 1; hd[i] = 0; sa[i] = i; sb[i] = i + G; sd[i] = 0; tg[i] = 0;
    end
    iv = 1; ordy = 1; fc = 0;
    @(negedge clk);
    in_valid = 1; out_ready = 1; free_cnt = 0;
    for (int i = 0; i < G; i++) begin
      slot_vld[i] = 1; slot_has_dst[i] = 0;
      src_a[i*AW +: AW] = AW'(i); src_b[i*AW +: AW] = AW'(i + G);
    end
    #1;
    for (int i = 0; i < G; i++) begin
      chk(psrc_a[i*PW +: PW] == PW'(model[i]), req, int'(psrc_a[i*PW +: PW]), model[i]);
      chk(psrc_b[i*PW +: PW] == PW'(model[i+G]), req, int'(psrc_b[i*PW +: PW]), model[i+G]);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    in_valid = 0; out_ready = 0; slot_vld = 0; slot_has_dst = 0;
    src_a = 0; src_b = 0; dst = 0; free_cnt = 0; free_tags = 0;
    for (int r = 0; r < ARCH; r++) model[r] = r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: identity after reset
    read_all("R1 reset map");
    @(posedge clk);
    // R7: all slots write R5, youngest wins
    for (int i = 0; i < G; i++) begin
      vl[i] = 1; hd[i] = 1; sa[i] = 5; sb[i] = 1; sd[i] = 5; tg[i] = 9 + i;
    end
    iv = 1; ordy = 1; fc = G;
    apply_and_check();
    read_all("R7 youngest writer");
    chk(psrc_b[1*PW +: PW] == PW'(9 + G - 1), "R7 table R5", int'(psrc_b[1*PW +: PW]), 9 + G - 1);
    @(posedge clk);
    // R8: short supply stalls and changes nothing
    for (int i = 0; i < G; i++) begin
      vl[i] = 1; hd[i] = (i < 2); sa[i] = 2; sb[i] = 3; sd[i] = i; tg[i] = 1;
    end
    iv = 1; ordy = 1; fc = 1;
    apply_and_check();
    read_all("R8 no change after stall");
    @(posedge clk);
    // R5: invalid slots with destinations leave the table alone
    for (int i = 0; i < G; i++) begin
      vl[i] = 0; hd[i] = 1; sa[i] = 0; sb[i] = 0; sd[i] = i; tg[i] = 15;
    end
    iv = 1; ordy = 1; fc = G;
    apply_and_check();
    read_all("R5 invalid slot no write");
    @(posedge clk);
    // sweep over dense collisions
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < G; i++) begin
        vl[i] = ($urandom % 8) != 0; hd[i] = ($urandom % 4) != 0;
        sa[i] = $urandom % ARCH; sb[i] = $urandom % ARCH; sd[i] = $urandom % ARCH;
        tg[i] = $urandom % PHYS;
      end
      iv = ($urandom % 10) != 0; ordy = ($urandom % 6) != 0;
      fc = ($urandom % 3 == 0) ? ($urandom % (G + 1)) : G;
      apply_and_check();
    end
    read_all("R2 final table");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule